// File: doc/BRIEF.md
# Multi-Channel Timer Register Front End

This block places two or three down-counting timer channels behind a single byte-addressed register space. A write or read strobe with an 8-bit byte address is decoded into one of four targets: a one-bit output-control register, a shared start register, a channel register window, or nothing at all. Each channel window holds three 32-bit words, and the word is chosen by the offset from the window base divided by four. Each bit of the start register separately runs or pauses one channel. Each channel drives its own interrupt line.

The channel windows sit at the uneven bases 0x08, 0x14 and 0x20. A build parameter removes the third channel together with its start bit. A second parameter removes the output-control register. Read data appears on the port one clock after the read strobe is sampled and is zero in every other cycle. In the channels used here, a running counter steps down once per clock. When it underflows it reloads from its reload word and raises a sticky flag. Software gates that flag onto the channel's interrupt line.

Top module: `tmu_front`

## Requirements
- R1: After synchronous reset, every stored value is zero: output control, start bits, and each channel's reload, count, interrupt enable and flag. `rdata` and all `irq` bits are 0.
- R2: Byte address 0x00 is the output-control register when HAS_OUTCTL=1. A write stores `wdata[0]` only, and a read returns it in bit 0 with all other bits zero. When HAS_OUTCTL=0, address 0x00 reads zero and writes to it are dropped.
- R3: Byte address 0x04 is the start register. A write stores `wdata[c]` as the run bit of channel c, and a read returns those bits with all higher bits zero.
- R4: Addresses 0x08–0x13 select channel 0, 0x14–0x1F select channel 1, and 0x20–0x2B select channel 2. The word index is (address − base) >> 2: word 0 is reload, word 1 is count and word 2 is control. The low two address bits are ignored inside a window.
- R5: While its run bit is 1, a channel's count drops by one each clock. In a clock where a running count is 0, the count loads the reload value instead and the flag is set.
- R6: While its run bit is 0, a channel's count holds. Setting the run bit again resumes counting from the held value.
- R7: Control word bit 5 is the interrupt enable and bit 8 is the flag; all other control bits read zero. `irq[c]` is 1 exactly when both are 1 for channel c. A control write with bit 8 = 0 clears the flag, and a control write with bit 8 = 1 leaves it unchanged.
- R8: If a count write and a count step fall in the same clock, the written value wins. If an underflow and a flag-clearing control write fall in the same clock, the flag ends up set.
- R9: With THREE_CH=0, start bit 2 is not stored and reads 0. Accesses to 0x20–0x2B read zero and have no effect, and `irq[2]` stays 0.
- R10: Reads of addresses that select no register (0x01–0x03, 0x05–0x07, 0x2C and above, and 0x00 when it is absent) return zero. Writes to those addresses change nothing.
- R11: `rdata` shows the read value one clock after `rd_en` is sampled high and is zero after any clock where `rd_en` was low. A read in the same clock as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | One interrupt line per channel (bit 2 is 0 without the third channel) |

## Verification
Two pairs of events can land in the same clock. A count write can coincide with the counter's own decrement or reload. A flag-clearing control write can coincide with an underflow. Both cases are provoked by writing a running channel whose reload value is zero: its count sits at zero, so it underflows on every clock and any write to it lands on an underflow. A behavioural model applies write priority for the count and underflow priority for the flag, and its read data and interrupt lines are compared with those of the design on every clock, in one build with three channels and one with two.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

    localparam int MAX_CH    = 3;
    localparam int ADDR_W    = 8;
    localparam int WIN_WORDS = 3;

    localparam logic [ADDR_W-1:0] OFS_OUTCTL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_START  = 8'h04;
    localparam logic [ADDR_W-1:0] BASE_CH0   = 8'h08;
    localparam logic [ADDR_W-1:0] BASE_CH1   = 8'h14;
    localparam logic [ADDR_W-1:0] BASE_CH2   = 8'h20;
    localparam logic [ADDR_W-1:0] WIN_BYTES  = ADDR_W'(WIN_WORDS * 4);

    localparam int CTL_IE_BIT   = 5;
    localparam int CTL_FLAG_BIT = 8;

    typedef enum logic [1:0] {
        T_NONE   = 2'd0,
        T_OUTCTL = 2'd1,
        T_START  = 2'd2,
        T_CHAN   = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        W_RELOAD = 2'd0,
        W_COUNT  = 2'd1,
        W_CTRL   = 2'd2,
        W_NONE   = 2'd3
    } word_e;

    typedef struct packed {
        tgt_e       tgt;
        logic [1:0] ch;
        word_e      widx;
    } dec_s;

    function automatic word_e word_of(input logic [ADDR_W-1:0] rel);
        return word_e'(2'(rel >> 2));
    endfunction

endpackage

// File: rtl/tmu_decode.sv
module tmu_decode
    import tmu_pkg::*;
#(
    parameter bit THREE_CH   = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_s              dec
);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        dec = '{tgt: T_NONE, ch: 2'd0, widx: W_NONE};
        rel = '0;
        if (addr >= BASE_CH2) begin
            rel = addr - BASE_CH2;
            if (THREE_CH && (rel < WIN_BYTES)) begin
                dec = '{tgt: T_CHAN, ch: 2'd2, widx: word_of(rel)};
            end
        end else if (addr >= BASE_CH1) begin
            rel = addr - BASE_CH1;
            dec = '{tgt: T_CHAN, ch: 2'd1, widx: word_of(rel)};
        end else if (addr >= BASE_CH0) begin
            rel = addr - BASE_CH0;
            dec = '{tgt: T_CHAN, ch: 2'd0, widx: word_of(rel)};
        end else if (addr == OFS_START) begin
            dec.tgt = T_START;
        end else if (HAS_OUTCTL && (addr == OFS_OUTCTL)) begin
            dec.tgt = T_OUTCTL;
        end
    end

endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
    import tmu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              wr,
    input  word_e             widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ie_q;
    logic             flag_q;

    logic wr_reload, wr_cnt, wr_ctl, uflow, clr_req;

    assign wr_reload = wr && (widx == W_RELOAD);
    assign wr_cnt    = wr && (widx == W_COUNT);
    assign wr_ctl    = wr && (widx == W_CTRL);
    assign uflow     = run && (cnt_q == '0);
    assign clr_req   = wr_ctl && !wdata[CTL_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cnt_q    <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata[CNT_W-1:0];

            if (wr_cnt)     cnt_q <= wdata[CNT_W-1:0];
            else if (uflow) cnt_q <= reload_q;
            else if (run)   cnt_q <= cnt_q - 1'b1;

            if (wr_ctl) ie_q <= wdata[CTL_IE_BIT];

            if (uflow)        flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (widx)
            W_RELOAD: rdata = DATA_W'(reload_q);
            W_COUNT:  rdata = DATA_W'(cnt_q);
            W_CTRL: begin
                rdata[CTL_IE_BIT]   = ie_q;
                rdata[CTL_FLAG_BIT] = flag_q;
            end
            default:  rdata = '0;
        endcase
    end

    assign irq = flag_q && ie_q;

    // R5: an underflow reloads the count and raises the flag
    a_r5_underflow_reload: assert property (@(posedge clk) disable iff (rst)
        (uflow && !wr_cnt) |=> ((cnt_q == $past(reload_q)) && flag_q));

    // R6: a stopped channel without a count write keeps its count
    a_r6_pause_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt_q));

    // R7: a flag-clearing write with no underflow removes the interrupt
    a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !uflow) |=> !irq);

    // R8: underflow wins over a clear in the same clock
    a_r8_underflow_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_req && uflow) |=> flag_q);

endmodule

// File: rtl/tmu_front.sv
module tmu_front
    import tmu_pkg::*;
#(
    parameter bit THREE_CH   = 1'b1,
    parameter bit HAS_OUTCTL = 1'b1,
    parameter int CNT_W      = 32,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [MAX_CH-1:0] irq
);

    localparam int NUM_CH = THREE_CH ? 3 : 2;

    dec_s              dec;
    logic [NUM_CH-1:0] start_q;
    logic              outctl_q;
    logic [DATA_W-1:0] ch_rd [MAX_CH];
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    tmu_decode #(
        .THREE_CH   (THREE_CH),
        .HAS_OUTCTL (HAS_OUTCTL)
    ) u_decode (
        .addr (addr),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr_en && (dec.tgt == T_START)) begin
            start_q <= wdata[NUM_CH-1:0];
        end
    end

    generate
        if (HAS_OUTCTL) begin : g_outctl
            always_ff @(posedge clk) begin
                if (rst) begin
                    outctl_q <= 1'b0;
                end else if (wr_en && (dec.tgt == T_OUTCTL)) begin
                    outctl_q <= wdata[0];
                end
            end
        end else begin : g_no_outctl
            assign outctl_q = 1'b0;
        end
    endgenerate

    generate
        for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
            if (c < NUM_CH) begin : g_live
                logic ch_wr;
                assign ch_wr = wr_en && (dec.tgt == T_CHAN) && (dec.ch == 2'(c));
                tmu_channel #(
                    .CNT_W  (CNT_W),
                    .DATA_W (DATA_W)
                ) u_chan (
                    .clk   (clk),
                    .rst   (rst),
                    .run   (start_q[c]),
                    .wr    (ch_wr),
                    .widx  (dec.widx),
                    .wdata (wdata),
                    .rdata (ch_rd[c]),
                    .irq   (irq[c])
                );
            end else begin : g_absent
                assign ch_rd[c] = '0;
                assign irq[c]   = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        unique case (dec.tgt)
            T_OUTCTL: rd_next[0] = outctl_q;
            T_START:  rd_next    = DATA_W'(start_q);
            T_CHAN: begin
                unique case (dec.ch)
                    2'd0:    rd_next = ch_rd[0];
                    2'd1:    rd_next = ch_rd[1];
                    2'd2:    rd_next = ch_rd[2];
                    default: rd_next = '0;
                endcase
            end
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
        else            rdata_q <= '0;
    end

    assign rdata = rdata_q;

    // R11: no read strobe, no data on the next clock
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rdata == '0));

    // R10: a read of an undecoded address returns zero
    a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (dec.tgt == T_NONE)) |=> (rdata == '0));

endmodule

// File: tb/test_tmu_front.sv
module test_tmu_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata_a, rdata_b;
    logic [2:0]  irq_a, irq_b;

    always #10 clk = ~clk;

    // build A: three channels with output control; build B: two channels, no output control
    tmu_front #(.THREE_CH(1'b1), .HAS_OUTCTL(1'b1)) i_tmu_front (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_a), .irq(irq_a));

    tmu_front #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) i_tmu_front_b (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_b), .irq(irq_b));

    // behavioural model state, index [build][channel]
    logic [31:0] m_rel [2][3];
    logic [31:0] m_cnt [2][3];
    logic        m_ie  [2][3];
    logic        m_flg [2][3];
    logic [2:0]  m_run [2];
    logic        m_oc  [2];
    logic [31:0] m_rd  [2];

    int    vectors = 0;
    int    fails   = 0;
    int    cyc     = 0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // kind: 0 none, 1 output control, 2 start, 3 channel word
    function automatic void decode_ref(input int b, input int a,
                                       output int kind, output int ch, output int w);
        int nch = (b == 0) ? 3 : 2;
        kind = 0; ch = 0; w = 0;
        if (a >= 32'h20) begin
            if (nch == 3 && a < 32'h2C) begin kind = 3; ch = 2; w = (a - 32'h20) / 4; end
        end else if (a >= 32'h14) begin
            kind = 3; ch = 1; w = (a - 32'h14) / 4;
        end else if (a >= 32'h08) begin
            kind = 3; ch = 0; w = (a - 32'h08) / 4;
        end else if (a == 4) begin
            kind = 2;
        end else if (a == 0 && b == 0) begin
            kind = 1;
        end
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int b = 0; b < 2; b++) begin
            if (rst) begin
                for (int c = 0; c < 3; c++) begin
                    m_rel[b][c] = 0; m_cnt[b][c] = 0; m_ie[b][c] = 0; m_flg[b][c] = 0;
                end
                m_run[b] = 0; m_oc[b] = 0; m_rd[b] = 0;
            end else begin
                int kind, ch, w, nch;
                logic [31:0] rv;
                nch = (b == 0) ? 3 : 2;
                decode_ref(b, int'(addr), kind, ch, w);
                rv = 0;
                case (kind)
                    1: rv = {31'b0, m_oc[b]};
                    2: rv = {29'b0, m_run[b]};
                    3: begin
                        if (w == 0) rv = m_rel[b][ch];
                        else if (w == 1) rv = m_cnt[b][ch];
                        else rv = (32'(m_ie[b][ch]) << 5) | (32'(m_flg[b][ch]) << 8);
                    end
                    default: rv = 0;
                endcase
                m_rd[b] = rd_en ? rv : 32'h0;
                for (int c = 0; c < nch; c++) begin
                    bit hit, uf, run;
                    hit = wr_en && kind == 3 && ch == c;
                    run = m_run[b][c];
                    uf  = run && m_cnt[b][c] == 0;
                    if (hit && w == 1) m_cnt[b][c] = wdata;
                    else if (uf) m_cnt[b][c] = m_rel[b][c];
                    else if (run) m_cnt[b][c] = m_cnt[b][c] - 1;
                    if (hit && w == 0) m_rel[b][c] = wdata;
                    if (hit && w == 2) m_ie[b][c] = wdata[5];
                    if (uf) m_flg[b][c] = 1'b1;
                    else if (hit && w == 2 && !wdata[8]) m_flg[b][c] = 1'b0;
                end
                if (wr_en && kind == 2) m_run[b] = (nch == 3) ? wdata[2:0] : {1'b0, wdata[1:0]};
                if (wr_en && kind == 1) m_oc[b] = wdata[0];
            end
        end
    end

    function automatic logic [2:0] irq_ref(input int b);
        logic [2:0] v = 0;
        for (int c = 0; c < 3; c++) v[c] = m_flg[b][c] && m_ie[b][c];
        return v;
    endfunction

    // compare both builds at every falling edge
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            vectors++;
            if (rdata_a !== m_rd[0] || irq_a !== irq_ref(0)) begin
                fails++;
                $display("FAIL %s build A: rdata %h irq %b, expected rdata %h irq %b",
                         cur_req, rdata_a, irq_a, m_rd[0], irq_ref(0));
            end
            vectors++;
            if (rdata_b !== m_rd[1] || irq_b !== irq_ref(1)) begin
                fails++;
                $display("FAIL %s build B: rdata %h irq %b, expected rdata %h irq %b",
                         cur_req, rdata_b, irq_b, m_rd[1], irq_ref(1));
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = a; wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic read_all;
        rd(8'h00); rd(8'h04);
        for (int a = 8; a < 8'h2C; a += 4) rd(8'(a));
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [7:0]  pick [13];
        pick = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                 8'h20, 8'h24, 8'h28, 8'h2C, 8'h05};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1"; read_all(); idle(2);

        cur_req = "R2"; wr(8'h00, 32'hFFFF_FFFF); rd(8'h00); wr(8'h00, 32'h0000_0002); rd(8'h00);

        cur_req = "R4";
        wr(8'h08, 32'h11); wr(8'h14, 32'h22); wr(8'h20, 32'h33);
        wr(8'h0C, 32'd100); wr(8'h18, 32'd200); wr(8'h24, 32'd300);
        read_all(); rd(8'h0D); rd(8'h17); rd(8'h2A);

        cur_req = "R3"; wr(8'h04, 32'hFFFF_FFFF); rd(8'h04); wr(8'h04, 32'h5); rd(8'h04);

        cur_req = "R5"; wr(8'h04, 32'h7); idle(5); read_all();

        cur_req = "R6"; wr(8'h04, 32'h0); idle(4); read_all(); read_all();
        wr(8'h04, 32'h3); idle(3); read_all();

        cur_req = "R7";
        wr(8'h04, 32'h0);
        wr(8'h08, 32'd2); wr(8'h14, 32'd4); wr(8'h20, 32'd1);
        wr(8'h0C, 32'd3); wr(8'h18, 32'd1); wr(8'h24, 32'd2);
        wr(8'h10, 32'hFFFF_FF20); wr(8'h1C, 32'h20); wr(8'h28, 32'h20);
        wr(8'h04, 32'h7); idle(6); read_all();
        wr(8'h04, 32'h0);
        wr(8'h10, 32'h120); rd(8'h10); wr(8'h10, 32'h20); rd(8'h10);
        wr(8'h1C, 32'h0); wr(8'h28, 32'h0); read_all();

        cur_req = "R8";
        wr(8'h08, 32'h0); wr(8'h0C, 32'h0); wr(8'h10, 32'h20);
        wr(8'h04, 32'h1); idle(2);
        wr(8'h10, 32'h20); rd(8'h10); wr(8'h10, 32'h20); idle(1);
        wr(8'h0C, 32'd9); rd(8'h0C); wr(8'h0C, 32'd50); idle(1); rd(8'h0C);
        wr(8'h04, 32'h0); wr(8'h10, 32'h20); rd(8'h10);

        cur_req = "R9";
        wr(8'h04, 32'h4); rd(8'h04); wr(8'h20, 32'h0); wr(8'h24, 32'h0);
        wr(8'h28, 32'h120); idle(3); read_all(); wr(8'h04, 32'h0); wr(8'h28, 32'h0);

        cur_req = "R10";
        wr(8'h01, 32'hFFFF_FFFF); wr(8'h05, 32'hFFFF_FFFF); wr(8'h07, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF); wr(8'hFF, 32'hFFFF_FFFF);
        rd(8'h01); rd(8'h06); rd(8'h2C); rd(8'h80); rd(8'hFF); read_all();

        cur_req = "R11";
        wr(8'h04, 32'h3); idle(4);
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'h0C; wdata = 32'd77;
        @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 8'h04; wdata = 32'h0;
        rd(8'h0C); idle(3);

        cur_req = "R8";
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(negedge clk);
            wr_en = lfsr[3] | lfsr[7];
            rd_en = lfsr[5];
            addr  = pick[lfsr[19:8] % 13];
            wdata = lfsr & 32'h0000_013F;
        end
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule